// File: doc/BRIEF.md
# Real-Time Clock Time-of-Day Update and Alarm Match

This block keeps the seconds, minutes and hours of a real-time clock. Once per second, on a pulse from the clock divider, it advances the time by one second. It carries from seconds into minutes and from minutes into hours. The three time bytes can be held as packed BCD or as plain binary. Hours can be kept on a 24-hour dial or as 1 to 12 with a PM flag. A control byte selects the encoding and the dial, and it also holds a freeze bit that stops the time from advancing while software loads new values.

After each counted second the block pulses an update-done event. In the same cycle it pulses an alarm event when the new time equals every alarm byte that is not a wildcard. The divider's sub-second phase drives an update-pending status bit. That bit is high during the last 8 phase counts before each second boundary, so software knows the time bytes are about to change.

Top module: `rtc_tod_core`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads 0x02 (24-hour dial, BCD, not frozen), all three time bytes read 0x00, and the update-done, alarm and update-pending outputs are 0.
- R2: In BCD mode (control bit 2 clear), each counted tick adds one second. Seconds and minutes roll from 0x59 to 0x00, and each roll carries into the next field. On the 24-hour dial (control bit 1 set), hours roll from 0x23 to 0x00.
- R3: In binary mode (control bit 2 set), the time bytes hold plain binary values and follow the same rollover points (59, 59, 23).
- R4: On the 12-hour dial (control bit 1 clear), the hour byte holds 1 to 12 in bits 6:0, and bit 7 is set for PM. 11 AM goes to 12 PM, 12 PM goes to 1 PM, 11 PM goes to 12 AM, and 12 AM goes to 1 AM.
- R5: A tick is counted when `tick_sec` is high and the freeze bit is clear. A counted tick updates the time bytes on the next clock edge, and `upd_evt` is high for exactly that one cycle.
- R6: `alm_evt` pulses together with `upd_evt` when the new time matches each alarm byte. An alarm byte whose bits 7:6 are both 1 is a wildcard and matches any value.
- R7: While control bit 7 (freeze) is set, ticks are ignored: the time bytes do not change and `upd_evt` stays low. A control write with bit 7 set stores bit 4 (update-event enable) as 0.
- R8: `uip` is registered. One cycle after `phase` is at least 2^PHASE_W − 8 while freeze is clear, `uip` reads 1. Otherwise it reads 0.
- R9: A time write (`tm_sel` 0 = seconds, 1 = minutes, 2 = hours) loads `tm_wdata` on the next edge. A tick in the same cycle as a time write is dropped. A write that makes the time equal the alarm does not raise `alm_evt`; only a later update can.
- R10: A control write with bit 7 clear stores the written byte unchanged, and `ctl_q` reads it back from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_sec | input | 1 | One-second pulse from the divider |
| phase | input | PHASE_W | Sub-second divider count |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| tm_wr | input | 1 | Time byte write strobe |
| tm_sel | input | 2 | Time byte select: 0 seconds, 1 minutes, 2 hours |
| tm_wdata | input | 8 | Time byte write data |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| ctl_q | output | 8 | Control byte |
| sec_q | output | 8 | Seconds byte |
| min_q | output | 8 | Minutes byte |
| hr_q | output | 8 | Hours byte |
| uip | output | 1 | Update-pending status |
| upd_evt | output | 1 | Update-done pulse |
| alm_evt | output | 1 | Alarm match pulse |

## Verification
The bench builds the block with PHASE_W = 6 and the 8-count pending window unchanged. A sweep of all 64 phase values therefore covers the whole pending window and the counts on both sides of it, with freeze set and with it clear. The time counters have no parameter to shrink, so the bench ticks through a full BCD hour across midnight. It also steps every hour of the day in each of the other three mode combinations, which reaches every seconds, minutes and hours rollover, including the four 12-hour transitions.

// File: rtl/rtc_tod_pkg.sv
// Package for the time-of-day core: control bit positions, the field select
// code and the BCD/binary conversion helpers. Assumes each time value fits in
// 7 bits (0..99).
package rtc_tod_pkg;

    localparam int CB_FREEZE = 7;
    localparam int CB_UIE    = 4;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;
    localparam logic [7:0] CTL_RST = 8'h02;

    localparam int NUM_FIELDS = 3;

    typedef enum logic [1:0] {
        FSEL_SEC = 2'd0,
        FSEL_MIN = 2'd1,
        FSEL_HR  = 2'd2
    } fsel_e;

    // Turn a stored byte into its numeric value (bit 7 ignored).
    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        logic [6:0] tens;
        tens = 7'(b[6:4]);
        return bin ? b[6:0] : (tens * 7'd10 + 7'(b[3:0]));
    endfunction

    // Turn a numeric value into the stored byte form.
    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [6:0] t;
        logic [6:0] u;
        t = v / 7'd10;
        u = v % 7'd10;
        return bin ? {1'b0, v} : {1'b0, t[2:0], u[3:0]};
    endfunction

endpackage

// File: rtl/rtc_field_ctr.sv
// One modulo counter for a seconds or minutes byte. It holds the byte, can be
// loaded directly, and steps by one when inc_en is high. wrap shows that the
// current value is at MAXV, so the next step rolls over and carries.
// Assumes the stored byte is legal for the active encoding.
module rtc_field_ctr
    import rtc_tod_pkg::*;
#(
    parameter int MAXV = 59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bin_mode,
    input  logic       inc_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] q,
    output logic [7:0] q_adv,
    output logic       wrap
);
    localparam logic [6:0] MAXV_L = 7'(MAXV);

    logic [6:0] cur_v;

    // Work out the value the field takes after one step.
    always_comb begin
        cur_v = dec_val(q, bin_mode);
        wrap  = (cur_v >= MAXV_L);
        q_adv = enc_val(wrap ? 7'd0 : cur_v + 7'd1, bin_mode);
    end

    // Field register: a load has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 8'h00;
        else if (wr_en)  q <= wr_data;
        else if (inc_en) q <= q_adv;
    end
endmodule

// File: rtl/rtc_hour_ctr.sv
// Hours register. It counts 0..23 on the 24-hour dial, or 1..12 with a PM
// flag in bit 7 on the 12-hour dial, in BCD or binary.
// Assumes the stored byte was written in the dial and encoding now active.
module rtc_hour_ctr
    import rtc_tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bin_mode,
    input  logic       h24,
    input  logic       inc_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] q,
    output logic [7:0] q_adv
);
    logic [6:0] hv;
    logic       pm;

    // Next hour on the selected dial.
    always_comb begin
        hv = dec_val({1'b0, q[6:0]}, bin_mode);
        pm = q[7];
        if (h24) begin
            q_adv = enc_val((hv >= 7'd23) ? 7'd0 : hv + 7'd1, bin_mode);
        end else if (hv == 7'd11) begin
            q_adv = enc_val(7'd12, bin_mode) | {~pm, 7'd0};
        end else if (hv >= 7'd12) begin
            q_adv = enc_val(7'd1, bin_mode) | {pm, 7'd0};
        end else begin
            q_adv = enc_val(hv + 7'd1, bin_mode) | {pm, 7'd0};
        end
    end

    // Hour register: a load has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 8'h00;
        else if (wr_en)  q <= wr_data;
        else if (inc_en) q <= q_adv;
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Compares a candidate time against the alarm bytes, one field at a time.
// An alarm byte with bits 7:6 both set matches anything. Assumes the time and
// alarm bytes share one encoding, so a byte-wise compare is enough.
module rtc_alarm_cmp #(
    parameter int NF = 3
) (
    input  logic [NF-1:0][7:0] now_t,
    input  logic [NF-1:0][7:0] alm,
    output logic               hit
);
    logic [NF-1:0] fld_ok;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        // Per-field match, with the wildcard code accepted.
        always_comb fld_ok[i] = (alm[i][7:6] == 2'b11) || (alm[i] == now_t[i]);
    end

    // Every field must agree.
    always_comb hit = &fld_ok;
endmodule

// File: rtl/rtc_uip_gen.sv
// Update-pending flag: high during the last HOLD_CYC counts of the divider
// phase before a second boundary, and only while the clock is running.
// Assumes phase counts up through 0..2^PHASE_W-1 once per second.
module rtc_uip_gen #(
    parameter int PHASE_W  = 15,
    parameter int HOLD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PHASE_W-1:0] phase,
    output logic               uip
);
    localparam logic [PHASE_W-1:0] THRESH = PHASE_W'((2 ** PHASE_W) - HOLD_CYC);

    // Register the window test.
    always_ff @(posedge clk) begin
        if (!rst_n) uip <= 1'b0;
        else        uip <= run && (phase >= THRESH);
    end
endmodule

// File: rtl/rtc_tod_core.sv
// Top of the time-of-day core. It holds the control byte and the three time
// counters, pulses an update-done event after each counted second, and
// checks the alarm against the time that update produces. Assumes tick_sec
// is a single-cycle pulse at most once per second.
module rtc_tod_core
    import rtc_tod_pkg::*;
#(
    parameter int PHASE_W  = 15,
    parameter int HOLD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_sec,
    input  logic [PHASE_W-1:0] phase,
    input  logic               ctl_wr,
    input  logic [7:0]         ctl_wdata,
    input  logic               tm_wr,
    input  logic [1:0]         tm_sel,
    input  logic [7:0]         tm_wdata,
    input  logic [7:0]         alm_sec,
    input  logic [7:0]         alm_min,
    input  logic [7:0]         alm_hr,
    output logic [7:0]         ctl_q,
    output logic [7:0]         sec_q,
    output logic [7:0]         min_q,
    output logic [7:0]         hr_q,
    output logic               uip,
    output logic               upd_evt,
    output logic               alm_evt
);
    localparam int NMS = 2;  // seconds and minutes use the same counter

    logic                          run;
    logic                          adv;
    logic                          bin_mode;
    logic                          h24;
    logic [NMS-1:0][7:0]           ms_q;
    logic [NMS-1:0][7:0]           ms_adv;
    logic [NMS-1:0]                ms_wrap;
    logic [NMS-1:0]                ms_inc;
    logic [NMS-1:0]                ms_wr;
    logic                          hr_inc;
    logic [7:0]                    hr_adv;
    logic [NUM_FIELDS-1:0][7:0]    new_t;
    logic [NUM_FIELDS-1:0][7:0]    alm_vec;
    logic                          alm_hit;

    // Decode the mode bits and decide whether this cycle counts a second.
    always_comb begin
        run      = !ctl_q[CB_FREEZE];
        bin_mode = ctl_q[CB_BIN];
        h24      = ctl_q[CB_H24];
        adv      = tick_sec && run && !tm_wr;
    end

    // Control byte: the update-event enable is dropped when freezing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_RST;
        else if (ctl_wr)
            ctl_q <= ctl_wdata[CB_FREEZE]
                   ? (ctl_wdata & ~(8'h01 << CB_UIE))
                   : ctl_wdata;
    end

    // Seconds and minutes counters with a ripple carry enable.
    for (genvar i = 0; i < NMS; i++) begin : g_ms
        if (i == 0) begin : g_first
            always_comb ms_inc[i] = adv;
        end else begin : g_next
            always_comb ms_inc[i] = ms_inc[i-1] && ms_wrap[i-1];
        end

        always_comb ms_wr[i] = tm_wr && (tm_sel == 2'(i));

        rtc_field_ctr #(.MAXV(59)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .bin_mode (bin_mode),
            .inc_en   (ms_inc[i]),
            .wr_en    (ms_wr[i]),
            .wr_data  (tm_wdata),
            .q        (ms_q[i]),
            .q_adv    (ms_adv[i]),
            .wrap     (ms_wrap[i])
        );

        // Value this field holds after the current update.
        always_comb new_t[i] = ms_inc[i] ? ms_adv[i] : ms_q[i];
    end

    // Hours step only when both lower fields roll over.
    always_comb hr_inc = ms_inc[NMS-1] && ms_wrap[NMS-1];

    rtc_hour_ctr u_hr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bin_mode (bin_mode),
        .h24      (h24),
        .inc_en   (hr_inc),
        .wr_en    (tm_wr && (tm_sel == FSEL_HR)),
        .wr_data  (tm_wdata),
        .q        (hr_q),
        .q_adv    (hr_adv)
    );

    // Candidate time and alarm vector, ordered seconds, minutes, hours.
    always_comb begin
        new_t[NUM_FIELDS-1] = hr_inc ? hr_adv : hr_q;
        alm_vec             = {alm_hr, alm_min, alm_sec};
        sec_q               = ms_q[0];
        min_q               = ms_q[1];
    end

    rtc_alarm_cmp #(.NF(NUM_FIELDS)) u_cmp (
        .now_t (new_t),
        .alm   (alm_vec),
        .hit   (alm_hit)
    );

    rtc_uip_gen #(.PHASE_W(PHASE_W), .HOLD_CYC(HOLD_CYC)) u_uip (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .phase (phase),
        .uip   (uip)
    );

    // Event pulses, one cycle after the counted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_evt <= 1'b0;
            alm_evt <= 1'b0;
        end else begin
            upd_evt <= adv;
            alm_evt <= adv && alm_hit;
        end
    end
endmodule

// File: rtl/rtc_tod_core_chk.sv
// Property checker for the time-of-day core, bound to every instance.
// Assumes a synchronous active-low reset; past_ok masks the first cycle.
module rtc_tod_core_chk #(
    parameter int PHASE_W  = 15,
    parameter int HOLD_CYC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_sec,
    input logic [PHASE_W-1:0] phase,
    input logic               tm_wr,
    input logic [7:0]         ctl_q,
    input logic [7:0]         sec_q,
    input logic [7:0]         min_q,
    input logic [7:0]         hr_q,
    input logic               uip,
    input logic               upd_evt,
    input logic               alm_evt
);
    localparam logic [PHASE_W-1:0] THRESH = PHASE_W'((2 ** PHASE_W) - HOLD_CYC);

    logic past_ok;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_upd_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        upd_evt |-> ($past(tick_sec) && !$past(tm_wr) && !$past(ctl_q[7])));

    assert_alarm_with_update_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        alm_evt |-> upd_evt);

    assert_freeze_holds_time_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(ctl_q[7]) && !$past(tm_wr)) |-> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

    assert_freeze_drops_uie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7] |-> !ctl_q[4]);

    assert_uip_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!$past(ctl_q[7]) && ($past(phase) >= THRESH)) |-> uip);

    assert_uip_off_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(ctl_q[7]) |-> !uip);
endmodule

bind rtc_tod_core rtc_tod_core_chk #(.PHASE_W(PHASE_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_sec (tick_sec),
    .phase    (phase),
    .tm_wr    (tm_wr),
    .ctl_q    (ctl_q),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hr_q     (hr_q),
    .uip      (uip),
    .upd_evt  (upd_evt),
    .alm_evt  (alm_evt)
);

// File: tb/rtc_tod_core_bench.sv
// Self-checking bench: sweeps phase, a full BCD hour and every hour of the day
// in each of the other three modes, with expected values computed here.
module rtc_tod_core_bench;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_sec = 1'b0;
    logic [PW-1:0] phase = '0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = 8'h00;
    logic          tm_wr = 1'b0;
    logic [1:0]    tm_sel = 2'd0;
    logic [7:0]    tm_wdata = 8'h00;
    logic [7:0]    alm_sec = 8'hC0;
    logic [7:0]    alm_min = 8'hC0;
    logic [7:0]    alm_hr = 8'hC0;
    logic [7:0]    ctl_q, sec_q, min_q, hr_q;
    logic          uip, upd_evt, alm_evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_tod_core #(.PHASE_W(PW), .HOLD_CYC(8)) u_rtc_tod_core (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .phase(phase),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tm_wr(tm_wr), .tm_sel(tm_sel),
        .tm_wdata(tm_wdata), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .ctl_q(ctl_q), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q),
        .uip(uip), .upd_evt(upd_evt), .alm_evt(alm_evt)
    );

    function automatic logic [7:0] enc(input int v, input bit bin);
        return bin ? 8'(v) : 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic logic [7:0] enc_hr(input int h, input bit bin, input bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_tm(input int sel, input logic [7:0] d);
        @(negedge clk); tm_wr = 1'b1; tm_sel = 2'(sel); tm_wdata = d;
        @(negedge clk); tm_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_sec = 1'b1;
        @(negedge clk); tick_sec = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int s, m, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctl", ctl_q, 8'h02);
        check("R1 sec", sec_q, 0);
        check("R1 min", min_q, 0);
        check("R1 hr", hr_q, 0);
        check("R1 upd", upd_evt, 0);
        check("R1 alm", alm_evt, 0);
        check("R1 uip", uip, 0);

        // R8 phase sweep, running then frozen
        for (int f = 0; f < 2; f++) begin
            wr_ctl(f ? 8'h82 : 8'h02);
            for (int p = 0; p < 64; p++) begin
                @(negedge clk); phase = PW'(p);
                @(negedge clk);
                check("R8 uip", uip, (f == 0 && p >= 56) ? 1 : 0);
            end
            phase = '0;
        end
        // R7 R10 freeze drops the update-event enable; plain write keeps bits
        wr_ctl(8'h92);
        check("R7 ctl uie cleared", ctl_q, 8'h82);
        wr_ctl(8'h12);
        check("R10 ctl stored", ctl_q, 8'h12);
        wr_ctl(8'h02);

        // R2 R5 R6 full BCD hour from 23:00:00 across midnight, alarm at sec 15
        alm_sec = 8'h15; alm_min = 8'hC0; alm_hr = 8'hC3;
        wr_tm(0, 8'h00); wr_tm(1, 8'h00); wr_tm(2, 8'h23);
        s = 0; m = 0; h = 23;
        for (int k = 0; k < 3600; k++) begin
            tick();
            s++;
            if (s == 60) begin s = 0; m++; end
            if (m == 60) begin m = 0; h = (h + 1) % 24; end
            check("R2 sec", sec_q, enc(s, 0));
            check("R2 min", min_q, enc(m, 0));
            check("R2 hr", hr_q, enc(h, 0));
            check("R5 upd", upd_evt, 1);
            check("R6 wildcard alarm", alm_evt, (s == 15) ? 1 : 0);
            @(negedge clk);
            check("R5 upd one cycle", upd_evt, 0);
        end
        alm_sec = 8'hC0; alm_hr = 8'h7F;

        // R3 R4 every hour boundary in the other three modes
        for (int md = 0; md < 3; md++) begin
            bit bin, h24;
            bin = (md != 1);
            h24 = (md == 0);
            wr_ctl({5'b0, bin, h24, 1'b0});
            for (int hh = 0; hh < 24; hh++) begin
                wr_tm(0, enc(59, bin)); wr_tm(1, enc(59, bin));
                wr_tm(2, enc_hr(hh, bin, h24));
                tick();
                check(h24 ? "R3 hr" : "R4 hr", hr_q, enc_hr((hh + 1) % 24, bin, h24));
                check("R3 sec", sec_q, 0);
                check("R3 min", min_q, 0);
            end
        end
        // R3 binary minute sweep
        wr_ctl(8'h06);
        wr_tm(0, 8'd0); wr_tm(1, 8'd10); wr_tm(2, 8'd5);
        for (int k = 1; k <= 60; k++) begin
            tick();
            check("R3 bin sec", sec_q, k % 60);
            check("R3 bin min", min_q, (k == 60) ? 11 : 10);
        end

        // R6 fully specified alarm, BCD 24h
        wr_ctl(8'h02);
        alm_hr = 8'h10; alm_min = 8'h20; alm_sec = 8'h30;
        wr_tm(0, 8'h28); wr_tm(1, 8'h20); wr_tm(2, 8'h10);
        tick();
        check("R6 no match", alm_evt, 0);
        tick();
        check("R6 match", alm_evt, 1);
        alm_hr = 8'hC0; alm_min = 8'h21;
        wr_tm(0, 8'h29);
        tick();
        check("R6 minute mismatch", alm_evt, 0);

        // R7 frozen ticks ignored
        wr_ctl(8'h82);
        wr_tm(0, 8'h44);
        tick();
        check("R7 sec frozen", sec_q, 8'h44);
        check("R7 no upd", upd_evt, 0);
        wr_ctl(8'h02);

        // R9 write with same-cycle tick drops the tick; no alarm from a write
        alm_hr = 8'hC0; alm_min = 8'hC0; alm_sec = 8'h40;
        @(negedge clk); tm_wr = 1'b1; tm_sel = 2'd0; tm_wdata = 8'h40; tick_sec = 1'b1;
        @(negedge clk); tm_wr = 1'b0; tick_sec = 1'b0;
        check("R9 write wins", sec_q, 8'h40);
        check("R9 tick dropped", upd_evt, 0);
        check("R9 no alarm on write", alm_evt, 0);
        wr_tm(0, 8'h39);
        check("R9 sec loaded", sec_q, 8'h39);
        tick();
        check("R9 alarm after update", alm_evt, 1);
        check("R9 sec", sec_q, 8'h40);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule